// File: doc/BRIEF.md
# Non-overlapping timed pattern output unit

This block is a timer-driven parallel pattern generator. A counter advances on prescaled ticks while a start input is high. It is compared against a period value and a margin value. Software or a DMA engine writes the next pattern into a staging register. A compare event then moves that staged pattern to the output pins. Per-pin next-data enables choose which pins follow the staging register. Each pin can also be loaded directly through an initial-value write.

Pins are grouped in fours. Each group is in one of two modes. A plain group takes its enabled staged bits on a selectable trigger event. A non-overlap group applies new data in two phases: bits going low change on the period event, and bits going high change on the later margin event of the same period. Inside such a group, a rising and a falling edge therefore never occur on the same clock. The margin event also raises an interrupt flag, which asks for the next pattern.

Top module: `nov_pattern_gen`

## Requirements
- R1: While `run` is 1, a prescaler produces one counter tick every 2^`presc_sel` clocks, and the counter advances once per tick. While `run` is 0, the counter and prescaler hold their values, so no compare event and no pin change occurs apart from initial-value writes.
- R2: `clr_sel` selects when the counter returns to zero. 2'b01 clears it after the period event, so one period lasts `period_val`+1 ticks. 2'b10 clears it after the margin event. 2'b00 and 2'b11 let it wrap freely.
- R3: A period event occurs on a tick where the counter equals `period_val`. A margin event occurs on a tick where the counter equals `margin_val`. The pins change on the clock edge of that tick.
- R4: Group g is pins 4g+3..4g and is controlled by `nov_mode[g]`. In a group with `nov_mode[g]`=0, enabled pins copy the staging register on the trigger event: the period event when `trig_sel`=0, or the margin event when `trig_sel`=1. A staging write takes effect one edge after `stage_we` is sampled.
- R5: In a group with `nov_mode[g]`=1, enabled pins that are 1 and staged 0 fall on the period event. Enabled pins that are 0 and staged 1 rise on the first margin event after that period event. A group never has a rise and a fall on the same edge.
- R6: When `margin_val` >= `period_val`, no rise takes place in a non-overlap group. Falls still occur on the period event.
- R7: A pin whose `nde` bit is 0 is never changed by the staging register.
- R8: Reset drives all pins and `irq` to 0. `init_we` loads all pins from `init_data` on the next edge, regardless of `nde`, and takes precedence over any compare update.
- R9: A margin event sets an interrupt flag. `irq_ack` clears the flag, but a margin event on the same edge wins. `irq` is the flag gated by `irq_en`.
- R10: `pin_oe` presents the direction bits `dir` unchanged, with 1 meaning that the pin is driven as an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter start; counts while 1 |
| presc_sel | input | 3 | Tick every 2^n clocks |
| clr_sel | input | 2 | Counter clear source |
| period_val | input | CNT_W | Period compare value |
| margin_val | input | CNT_W | Margin compare value |
| trig_sel | input | 1 | Trigger for plain groups: 0 period, 1 margin |
| nov_mode | input | WIDTH/4 | Per-group non-overlap mode |
| nde | input | WIDTH | Per-pin next-data enable |
| dir | input | WIDTH | Per-pin direction, 1 = output |
| stage_we | input | 1 | Staging register write strobe |
| stage_data | input | WIDTH | Next pattern |
| init_we | input | 1 | Direct pin value write strobe |
| init_data | input | WIDTH | Direct pin value |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt flag clear |
| pins_out | output | WIDTH | Pattern output |
| pin_oe | output | WIDTH | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with WIDTH=8 and CNT_W=8. This gives one non-overlap group and one plain group side by side, so falls, delayed rises and plain copies can be seen on the same period. Small compare values keep each period to a few ticks, which puts both clear sources, a margin equal to the period, and a prescale of four within a short run. Every pin change is matched against a queue of expected values and the clock cycle on which each should appear.

// File: rtl/nov_pattern_gen.sv
module nov_pattern_gen #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [2:0]         presc_sel,
  input  logic [1:0]         clr_sel,
  input  logic [CNT_W-1:0]   period_val,
  input  logic [CNT_W-1:0]   margin_val,
  input  logic               trig_sel,
  input  logic [WIDTH/4-1:0] nov_mode,
  input  logic [WIDTH-1:0]   nde,
  input  logic [WIDTH-1:0]   dir,
  input  logic               stage_we,
  input  logic [WIDTH-1:0]   stage_data,
  input  logic               init_we,
  input  logic [WIDTH-1:0]   init_data,
  input  logic               irq_en,
  input  logic               irq_ack,
  output logic [WIDTH-1:0]   pins_out,
  output logic [WIDTH-1:0]   pin_oe,
  output logic               irq
);
  localparam int PW = 7;

  logic [PW-1:0]    pre_cnt;
  logic [PW-1:0]    pre_mask;
  logic [CNT_W-1:0] cnt;
  logic [WIDTH-1:0] stage;
  logic [WIDTH-1:0] nov_mask;
  logic             tick, cmp_p, cmp_m, clr, armed, rise_ok, trig, flag;

  assign pre_mask = ~({PW{1'b1}} << presc_sel);
  assign tick     = run && ((pre_cnt & pre_mask) == pre_mask);
  assign cmp_p    = tick && (cnt == period_val);
  assign cmp_m    = tick && (cnt == margin_val);
  assign clr      = (clr_sel == 2'b01 && cmp_p) || (clr_sel == 2'b10 && cmp_m);
  assign trig     = trig_sel ? cmp_m : cmp_p;
  assign rise_ok  = armed && cmp_m && !cmp_p && (margin_val < period_val);

  for (genvar i = 0; i < WIDTH; i++) begin : g_grp
    assign nov_mask[i] = nov_mode[i/4];
  end

  logic [WIDTH-1:0] fall_v, rise_v, copy_v, out_next;
  assign fall_v   = nde & nov_mask & pins_out & ~stage & {WIDTH{cmp_p}};
  assign rise_v   = nde & nov_mask & ~pins_out & stage & {WIDTH{rise_ok}};
  assign copy_v   = nde & ~nov_mask & {WIDTH{trig}};
  assign out_next = (pins_out & ~copy_v & ~fall_v) | (stage & copy_v) | rise_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      cnt      <= '0;
      stage    <= '0;
      pins_out <= '0;
      armed    <= 1'b0;
      flag     <= 1'b0;
    end else begin
      if (run) pre_cnt <= pre_cnt + 1'b1;
      if (tick) cnt <= clr ? '0 : cnt + 1'b1;
      if (stage_we) stage <= stage_data;
      pins_out <= init_we ? init_data : out_next;
      if (cmp_p) armed <= 1'b1;
      else if (cmp_m) armed <= 1'b0;
      if (cmp_m) flag <= 1'b1;
      else if (irq_ack) flag <= 1'b0;
    end
  end

  assign irq    = flag & irq_en;
  assign pin_oe = dir;
endmodule

module nov_pattern_gen_chk #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic               init_we,
  input logic [WIDTH-1:0]   nde,
  input logic [WIDTH/4-1:0] nov_mode,
  input logic [CNT_W-1:0]   period_val,
  input logic [CNT_W-1:0]   margin_val,
  input logic               irq_ack,
  input logic               cmp_m,
  input logic [WIDTH-1:0]   pins_out,
  input logic               irq
);
  logic [WIDTH-1:0] gmask;
  for (genvar i = 0; i < WIDTH; i++) begin : g_m
    assign gmask[i] = nov_mode[i/4];
  end

  p_frozen_when_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !init_we) |=> $stable(pins_out)) else $error("frozen");

  p_masked_bits_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !init_we |=> (((pins_out ^ $past(pins_out)) & ~$past(nde)) == '0)) else $error("nde");

  p_rise_after_margin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !init_we |=> (((pins_out & ~$past(pins_out) & $past(gmask)) == '0) || $past(cmp_m)))
    else $error("rise timing");

  p_no_rise_when_margin_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_we && margin_val >= period_val) |=> ((pins_out & ~$past(pins_out) & $past(gmask)) == '0))
    else $error("late margin rise");

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !cmp_m) |=> !irq) else $error("ack");

  for (genvar g = 0; g < WIDTH/4; g++) begin : g_ov
    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_we && nov_mode[g]) |=>
        !((|(pins_out[4*g +: 4] & ~$past(pins_out[4*g +: 4]))) &&
          (|(~pins_out[4*g +: 4] & $past(pins_out[4*g +: 4])))))
      else $error("overlap");
  end
endmodule

bind nov_pattern_gen nov_pattern_gen_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .init_we(init_we), .nde(nde),
  .nov_mode(nov_mode), .period_val(period_val), .margin_val(margin_val),
  .irq_ack(irq_ack), .cmp_m(cmp_m), .pins_out(pins_out), .irq(irq)
);

// File: tb/nov_pattern_gen_tb.sv
module nov_pattern_gen_tb;
  localparam int W = 8;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0, run = 0, trig_sel = 0, stage_we = 0, init_we = 0;
  logic irq_en = 0, irq_ack = 0;
  logic [2:0] presc_sel = 0;
  logic [1:0] clr_sel = 0;
  logic [CW-1:0] period_val = 0, margin_val = 0;
  logic [W/4-1:0] nov_mode = 0;
  logic [W-1:0] nde = 0, dir = 0, stage_data = 0, init_data = 0;
  logic [W-1:0] pins_out, pin_oe;
  logic irq;

  int cyc = 0, checks = 0, errors = 0, s = 0;
  logic [W-1:0] exp_val[$];
  int exp_cyc[$];
  string exp_tag[$];
  logic [W-1:0] last = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nov_pattern_gen #(.WIDTH(W), .CNT_W(CW)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] v, input int c, input string tag);
    exp_val.push_back(v); exp_cyc.push_back(c); exp_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (!rst_n) last = pins_out;
    else if (pins_out !== last) begin
      if (exp_val.size() == 0) chk(0, "R7 unexpected pin change", pins_out, last);
      else begin
        logic [W-1:0] v; int c; string t;
        v = exp_val.pop_front(); c = exp_cyc.pop_front(); t = exp_tag.pop_front();
        chk(pins_out == v, {t, " value"}, pins_out, v);
        chk(cyc == c, {t, " cycle"}, cyc, c);
      end
      last = pins_out;
    end
  end

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; run = 0; stage_we = 0; init_we = 0; irq_ack = 0; irq_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic stage_write(input logic [W-1:0] v);
    stage_data = v; stage_we = 1;
    @(negedge clk);
    stage_we = 0;
  endtask

  task automatic init_write(input logic [W-1:0] v);
    push(v, cyc + 1, "R8 init");
    init_data = v; init_we = 1;
    @(negedge clk);
    init_we = 0;
  endtask

  task automatic drained(input string tag);
    chk(exp_val.size() == 0, {tag, " queue drained"}, exp_val.size(), 0);
  endtask

  initial begin
    do_reset();
    chk(pins_out == 0, "R8 reset pins", pins_out, 0);
    chk(irq == 0, "R8 reset irq", irq, 0);
    dir = 8'hF3; #1;
    chk(pin_oe == 8'hF3, "R10 pin_oe", pin_oe, 8'hF3);

    // Scenario A: group0 non-overlap, group1 plain, period 9, margin 3
    presc_sel = 0; clr_sel = 2'b01; period_val = 9; margin_val = 3;
    nov_mode = 2'b01; trig_sel = 0; nde = 8'hFF; irq_en = 1;
    stage_write(8'hA3);
    init_write(8'h35);
    s = cyc;
    push(8'hA1, s + 10, "R5 fall on period");
    push(8'hA3, s + 14, "R5 rise on margin");
    push(8'h50, s + 20, "R2 second period");
    push(8'h5C, s + 24, "R5 second rise");
    run = 1;
    wait_until(s + 4);
    chk(irq == 1, "R9 irq set by margin", irq, 1);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    chk(irq == 0, "R9 irq cleared by ack", irq, 0);
    wait_until(s + 14);
    chk(irq == 1, "R9 irq set again", irq, 1);
    wait_until(s + 15);
    stage_write(8'h5C);
    wait_until(s + 30);
    chk(pins_out == 8'h5C, "R5 final pattern", pins_out, 8'h5C);
    drained("R2");

    // Scenario B: margin equal to period, rises suppressed
    do_reset();
    clr_sel = 2'b01; period_val = 5; margin_val = 5; nov_mode = 2'b01;
    trig_sel = 0; nde = 8'hFF;
    stage_write(8'h5F);
    s = cyc;
    push(8'h50, s + 6, "R4 plain group copy");
    run = 1;
    wait_until(s + 30);
    chk(pins_out == 8'h50, "R6 no rise with late margin", pins_out, 8'h50);
    drained("R6");

    // Scenario C: plain groups on margin trigger, low nibble disabled
    do_reset();
    clr_sel = 2'b01; period_val = 7; margin_val = 2; nov_mode = 2'b00;
    trig_sel = 1; nde = 8'hF0; irq_en = 0;
    stage_write(8'h93);
    init_write(8'h0C);
    s = cyc;
    push(8'h9C, s + 3, "R4 margin trigger");
    push(8'h6C, s + 11, "R7 masked bits hold");
    run = 1;
    wait_until(s + 4);
    chk(irq == 0, "R9 irq gated off", irq, 0);
    wait_until(s + 5);
    stage_write(8'h6F);
    irq_en = 1; #1;
    chk(irq == 1, "R9 irq after enable", irq, 1);
    wait_until(s + 20);
    chk(pins_out == 8'h6C, "R7 final", pins_out, 8'h6C);
    drained("R4");

    // Scenario D: prescale by 4, then stop
    do_reset();
    presc_sel = 3'd2; clr_sel = 2'b01; period_val = 2; margin_val = 1;
    nov_mode = 2'b00; trig_sel = 0; nde = 8'hFF; irq_en = 1;
    stage_write(8'hFF);
    s = cyc;
    push(8'hFF, s + 12, "R1 prescaled period");
    run = 1;
    wait_until(s + 7);
    chk(irq == 0, "R1 no margin before tick", irq, 0);
    wait_until(s + 8);
    chk(irq == 1, "R1 margin on prescaled tick", irq, 1);
    wait_until(s + 13);
    run = 0;
    stage_write(8'h00);
    wait_until(s + 50);
    chk(pins_out == 8'hFF, "R1 frozen while stopped", pins_out, 8'hFF);
    drained("R1");

    // Scenario E: clear on margin event
    do_reset();
    presc_sel = 0; clr_sel = 2'b10; period_val = 1; margin_val = 2;
    nov_mode = 2'b00; trig_sel = 0; nde = 8'hFF;
    stage_write(8'h11);
    s = cyc;
    push(8'h11, s + 2, "R3 period compare");
    push(8'h22, s + 5, "R2 clear on margin");
    run = 1;
    wait_until(s + 3);
    stage_write(8'h22);
    wait_until(s + 20);
    chk(pins_out == 8'h22, "R2 final", pins_out, 8'h22);
    drained("R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule